// File: doc/BRIEF.md
# Memory Mode Register Command Decoder

This block sits on the device side of a graphics DRAM model. Each clock it samples the command strobes. When a register-load command arrives, the bank-select bits choose where it goes. Code 00 targets the main mode register and code 01 targets the extended mode register.

A main-register load is checked before it is accepted. Any violation raises a sticky error flag and leaves the stored settings alone. An accepted load is decoded into these settings:
- read latency
- write latency
- burst length
- burst type
- test mode
- a single-cycle DLL reset strobe

Any field that carries an undefined code keeps its earlier value and raises a sticky reserved-code flag. After every accepted load, a busy window lasting a parameterised number of cycles locks out further loads.

The surrounding model reads the decoded settings once the valid output is high. It watches busy so that it does not issue a new load during the lockout. An extended-register load only records that it has happened; decoding its contents is done elsewhere.

Top module: `mode_cfg_decoder`

## Requirements
- R1: A load command is recognised on a rising clock edge only when clk_en_i is 1 and cmd_sel_n_i, cmd_row_n_i, cmd_col_n_i and cmd_wr_n_i are all 0. If clk_en_i is 0, or any strobe is 1, nothing changes.
- R2: A recognised command with bank_sel_i = 2'b00 targets the main register. With 2'b01 it targets the extended register. With 2'b10 or 2'b11 it is ignored entirely.
- R3: Burst length comes from addr_i[1:0]. Code 2'b10 gives 4, 2'b11 gives 8, and 2'b00 and 2'b01 are reserved.
- R4: Read latency uses the 4-bit code {addr_i[2], addr_i[6], addr_i[5], addr_i[4]}. Codes 0000 to 0011 give 8 to 11, codes 0100 to 0111 give 4 to 7, and codes 1xxx are reserved.
- R5: Write latency comes from addr_i[11:9]. Codes 1 to 7 give the same number of cycles, and code 000 is reserved.
- R6: burst_type_o follows addr_i[3], where 0 means sequential and 1 is reserved. test_mode_o follows addr_i[7] on every accepted main load.
- R7: An accepted main load with addr_i[8] = 1 drives dll_rst_o high for exactly the one cycle after the load edge. Nothing else ever drives it high.
- R8: busy_o is high for TMRD cycles after every accepted load, either main or extended. A load sampled while busy_o is high is rejected.
- R9: A load is rejected if it is sampled while busy_o is high or while any bit of bank_act_i is set. A rejected load sets the sticky err_o and changes neither the settings nor ext_done_o.
- R10: A main load that arrives before any accepted extended load is rejected and sets err_o.
- R11: For an accepted main load, any field carrying a reserved code keeps its previous value and sets the sticky rsvd_o. The fields with defined codes are still updated.
- R12: After reset all outputs are 0. cfg_valid_o rises on the first accepted main load and ext_done_o rises on the first accepted extended load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Clock enable; must be 1 for a command to be recognised |
| cmd_sel_n_i | input | 1 | Chip-select command strobe, active low |
| cmd_row_n_i | input | 1 | Row command strobe, active low |
| cmd_col_n_i | input | 1 | Column command strobe, active low |
| cmd_wr_n_i | input | 1 | Write command strobe, active low |
| bank_sel_i | input | 2 | Register target select |
| addr_i | input | 12 | Load payload |
| bank_act_i | input | NUM_BANKS | Open-bank mask |
| rd_lat_o | output | 4 | Read latency in cycles |
| wr_lat_o | output | 3 | Write latency in cycles |
| burst_len_o | output | 4 | Burst length in beats |
| burst_type_o | output | 1 | Burst type, 0 means sequential |
| test_mode_o | output | 1 | Test mode enable |
| dll_rst_o | output | 1 | One-cycle DLL reset strobe |
| cfg_valid_o | output | 1 | Settings have been loaded at least once |
| ext_done_o | output | 1 | An extended load has been accepted |
| busy_o | output | 1 | Lockout window after a load is active |
| err_o | output | 1 | Sticky flag for a rejected load |
| rsvd_o | output | 1 | Sticky flag for a reserved code |

## Verification
The main decode is driven with all 4096 payload values in turn, each as an accepted main load. This sweep separates the wrapped read-latency code from a straight binary mapping. It also shows that each reserved field is held on its own while the neighbouring fields still update. Negative patterns are used alongside the sweep:
- clock enable low
- each strobe high in turn
- bank-select codes 2 and 3

These show that near-miss commands leave no trace. Loads are also placed one cycle before and exactly at the end of the busy window, inside an open-bank condition for each bank, and ahead of any extended load. These cases separate an accepted load from a rejected one by the error flag and by whether the held settings stay unchanged.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
    localparam int ADDR_W = 12;

    localparam int BL_LO  = 0;
    localparam int BT_BIT = 3;
    localparam int RL_HI  = 2;
    localparam int RL_LO  = 4;
    localparam int TM_BIT = 7;
    localparam int DLL_BIT = 8;
    localparam int WL_LO  = 9;

    typedef struct packed {
        logic [3:0] rl;
        logic [2:0] wl;
        logic [3:0] bl;
        logic       bt;
        logic       tm;
    } mode_set_t;
endpackage

// File: rtl/mcd_cmd_detect.sv
module mcd_cmd_detect #(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk_en_i,
    input  logic                 cmd_sel_n_i,
    input  logic                 cmd_row_n_i,
    input  logic                 cmd_col_n_i,
    input  logic                 cmd_wr_n_i,
    input  logic [1:0]           bank_sel_i,
    input  logic [NUM_BANKS-1:0] bank_act_i,
    output logic                 main_hit_o,
    output logic                 ext_hit_o,
    output logic                 idle_o
);
    logic load_cmd;

    always_comb begin
        load_cmd   = clk_en_i & ~cmd_sel_n_i & ~cmd_row_n_i & ~cmd_col_n_i & ~cmd_wr_n_i;
        main_hit_o = load_cmd & (bank_sel_i == 2'b00);
        ext_hit_o  = load_cmd & (bank_sel_i == 2'b01);
        idle_o     = ~|bank_act_i;
    end
endmodule

// File: rtl/mcd_field_decode.sv
module mcd_field_decode
    import mcd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output mode_set_t         cand_o,
    output logic              rl_ok_o,
    output logic              wl_ok_o,
    output logic              bl_ok_o,
    output logic              bt_ok_o
);
    logic [3:0] rl_code;

    always_comb begin
        rl_code   = {addr_i[RL_HI], addr_i[RL_LO+2], addr_i[RL_LO+1], addr_i[RL_LO]};
        rl_ok_o   = ~rl_code[3];
        cand_o.rl = rl_code[2] ? {2'b01, rl_code[1:0]} : {2'b10, rl_code[1:0]};

        cand_o.wl = addr_i[WL_LO+2:WL_LO];
        wl_ok_o   = |cand_o.wl;

        bl_ok_o   = addr_i[BL_LO+1];
        cand_o.bl = addr_i[BL_LO] ? 4'd8 : 4'd4;

        cand_o.bt = addr_i[BT_BIT];
        bt_ok_o   = ~addr_i[BT_BIT];

        cand_o.tm = addr_i[TM_BIT];
    end

    always_comb begin
        a_r4_rl_range: assert (!rl_ok_o || (cand_o.rl >= 4'd4 && cand_o.rl <= 4'd11));
    end
endmodule

// File: rtl/mode_cfg_decoder.sv
module mode_cfg_decoder
    import mcd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int TMRD      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_en_i,
    input  logic                 cmd_sel_n_i,
    input  logic                 cmd_row_n_i,
    input  logic                 cmd_col_n_i,
    input  logic                 cmd_wr_n_i,
    input  logic [1:0]           bank_sel_i,
    input  logic [11:0]          addr_i,
    input  logic [NUM_BANKS-1:0] bank_act_i,
    output logic [3:0]           rd_lat_o,
    output logic [2:0]           wr_lat_o,
    output logic [3:0]           burst_len_o,
    output logic                 burst_type_o,
    output logic                 test_mode_o,
    output logic                 dll_rst_o,
    output logic                 cfg_valid_o,
    output logic                 ext_done_o,
    output logic                 busy_o,
    output logic                 err_o,
    output logic                 rsvd_o
);
    localparam int CNT_W = $clog2(TMRD + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TMRD);

    typedef struct packed {
        mode_set_t        cfg;
        logic             valid;
        logic             ext_done;
        logic             err;
        logic             rsvd;
        logic             dll;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t    s_d, s_q;
    logic      main_hit, ext_hit, idle;
    mode_set_t cand;
    logic      rl_ok, wl_ok, bl_ok, bt_ok;
    logic      blocked;

    mcd_cmd_detect #(.NUM_BANKS(NUM_BANKS)) u_cmd (
        .clk_en_i    (clk_en_i),
        .cmd_sel_n_i (cmd_sel_n_i),
        .cmd_row_n_i (cmd_row_n_i),
        .cmd_col_n_i (cmd_col_n_i),
        .cmd_wr_n_i  (cmd_wr_n_i),
        .bank_sel_i  (bank_sel_i),
        .bank_act_i  (bank_act_i),
        .main_hit_o  (main_hit),
        .ext_hit_o   (ext_hit),
        .idle_o      (idle)
    );

    mcd_field_decode u_fld (
        .addr_i  (addr_i),
        .cand_o  (cand),
        .rl_ok_o (rl_ok),
        .wl_ok_o (wl_ok),
        .bl_ok_o (bl_ok),
        .bt_ok_o (bt_ok)
    );

    always_comb begin
        s_d     = s_q;
        s_d.dll = 1'b0;
        if (s_q.cnt != '0) s_d.cnt = s_q.cnt - 1'b1;
        blocked = (s_q.cnt != '0) || !idle;

        if (ext_hit) begin
            if (blocked) begin
                s_d.err = 1'b1;
            end else begin
                s_d.ext_done = 1'b1;
                s_d.cnt      = CNT_LOAD;
            end
        end

        if (main_hit) begin
            if (blocked || !s_q.ext_done) begin
                s_d.err = 1'b1;
            end else begin
                s_d.valid  = 1'b1;
                s_d.cnt    = CNT_LOAD;
                s_d.dll    = addr_i[DLL_BIT];
                s_d.cfg.tm = cand.tm;
                if (rl_ok) s_d.cfg.rl = cand.rl; else s_d.rsvd = 1'b1;
                if (wl_ok) s_d.cfg.wl = cand.wl; else s_d.rsvd = 1'b1;
                if (bl_ok) s_d.cfg.bl = cand.bl; else s_d.rsvd = 1'b1;
                if (bt_ok) s_d.cfg.bt = cand.bt; else s_d.rsvd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_lat_o     = s_q.cfg.rl;
    assign wr_lat_o     = s_q.cfg.wl;
    assign burst_len_o  = s_q.cfg.bl;
    assign burst_type_o = s_q.cfg.bt;
    assign test_mode_o  = s_q.cfg.tm;
    assign dll_rst_o    = s_q.dll;
    assign cfg_valid_o  = s_q.valid;
    assign ext_done_o   = s_q.ext_done;
    assign busy_o       = (s_q.cnt != '0);
    assign err_o        = s_q.err;
    assign rsvd_o       = s_q.rsvd;

    a_r7_dll_single: assert property (@(posedge clk) disable iff (!rst_n)
        dll_rst_o |=> !dll_rst_o);
    a_r8_busy_after_main: assert property (@(posedge clk) disable iff (!rst_n)
        (main_hit && !busy_o && idle && ext_done_o) |=> busy_o);
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    a_r9_hold_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        (main_hit && !idle) |=> ($stable(rd_lat_o) && $stable(wr_lat_o) && $stable(burst_len_o) && !dll_rst_o));
    a_r10_valid_needs_ext: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid_o |-> ext_done_o);
    a_r11_rsvd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_o |=> rsvd_o);
    a_r12_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid_o |=> cfg_valid_o);
    a_r3_bl_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid_o && !rsvd_o |-> (burst_len_o == 4'd4 || burst_len_o == 4'd8));
endmodule

// File: tb/tb_mode_cfg_decoder.sv
`timescale 1ns/1ps
module tb_mode_cfg_decoder;
    localparam int NB   = 4;
    localparam int TMRD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en, sel_n, row_n, col_n, wr_n;
    logic [1:0] bsel;
    logic [11:0] addr;
    logic [NB-1:0] bact;
    logic [3:0] rd_lat, burst_len;
    logic [2:0] wr_lat;
    logic bt, tm, dll, valid, ext_done, busy, err, rsvd;

    int tests = 0;
    int fails = 0;

    int e_rl, e_wl, e_bl, e_bt, e_tm, e_valid, e_ext, e_err, e_rsvd;

    always #2 clk = ~clk;

    mode_cfg_decoder #(.NUM_BANKS(NB), .TMRD(TMRD)) dut (
        .clk(clk), .rst_n(rst_n), .clk_en_i(clk_en),
        .cmd_sel_n_i(sel_n), .cmd_row_n_i(row_n), .cmd_col_n_i(col_n), .cmd_wr_n_i(wr_n),
        .bank_sel_i(bsel), .addr_i(addr), .bank_act_i(bact),
        .rd_lat_o(rd_lat), .wr_lat_o(wr_lat), .burst_len_o(burst_len),
        .burst_type_o(bt), .test_mode_o(tm), .dll_rst_o(dll),
        .cfg_valid_o(valid), .ext_done_o(ext_done), .busy_o(busy),
        .err_o(err), .rsvd_o(rsvd)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        check({req, " rd_lat"}, rd_lat, e_rl);
        check({req, " wr_lat"}, wr_lat, e_wl);
        check({req, " burst_len"}, burst_len, e_bl);
        check({req, " burst_type"}, bt, e_bt);
        check({req, " test_mode"}, tm, e_tm);
        check({req, " valid"}, valid, e_valid);
        check({req, " ext_done"}, ext_done, e_ext);
        check({req, " err"}, err, e_err);
        check({req, " rsvd"}, rsvd, e_rsvd);
    endtask

    task automatic nop();
        clk_en = 1'b1; sel_n = 1'b1; row_n = 1'b1; col_n = 1'b1; wr_n = 1'b1;
        bsel = 2'b00; addr = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        nop(); bact = '0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        e_rl = 0; e_wl = 0; e_bl = 0; e_bt = 0; e_tm = 0;
        e_valid = 0; e_ext = 0; e_err = 0; e_rsvd = 0;
    endtask

    // drive a load at the current negedge; returns at the next negedge with NOP driven
    task automatic load(input logic [1:0] b, input logic [11:0] a);
        bsel = b; addr = a; sel_n = 1'b0; row_n = 1'b0; col_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        nop();
    endtask

    // expected effect of an accepted main load
    task automatic model_main(input logic [11:0] a);
        int low;
        e_valid = 1;
        e_tm = a[7];
        low = a[5] * 2 + a[4];
        if (a[2]) e_rsvd = 1; else e_rl = a[6] ? 4 + low : 8 + low;
        if (a[11:9] == 3'd0) e_rsvd = 1; else e_wl = a[11:9];
        if (!a[1]) e_rsvd = 1; else e_bl = a[0] ? 8 : 4;
        if (a[3]) e_rsvd = 1; else e_bt = 0;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        nop(); bact = '0;
        do_reset();
        @(negedge clk);
        // R12 reset state
        check_state("R12 reset");
        check("R12 reset busy", busy, 0);
        check("R12 reset dll", dll, 0);

        // R1 near-miss commands: main load before ext would set err if recognised
        for (int k = 0; k < 5; k++) begin
            bsel = 2'b00; addr = 12'hFFF;
            sel_n = (k == 0); row_n = (k == 1); col_n = (k == 2); wr_n = (k == 3);
            clk_en = (k != 4);
            @(negedge clk);
            nop();
            check("R1 near-miss err", err, 0);
            check("R1 near-miss busy", busy, 0);
        end

        // R2 bank select 2 and 3 ignored
        for (int b = 2; b < 4; b++) begin
            load(b[1:0], 12'h000);
            check("R2 ignored err", err, 0);
            check("R2 ignored busy", busy, 0);
            check("R2 ignored ext_done", ext_done, 0);
        end

        // R10 main load before ext
        load(2'b00, 12'h0A6);
        e_err = 1;
        check_state("R10 main before ext");
        check("R10 no busy", busy, 0);

        // R9 ext load while a bank is open
        do_reset();
        bact = 4'b0100;
        load(2'b01, 12'h000);
        bact = '0;
        e_err = 1;
        check_state("R9 ext with open bank");

        // R8 busy window after ext
        do_reset();
        load(2'b01, 12'h000);
        e_ext = 1;
        check_state("R2 ext accepted");
        for (int c = 1; c <= TMRD; c++) begin
            check("R8 busy inside window", busy, 1);
            @(negedge clk);
        end
        check("R8 busy released", busy, 0);

        // R8 boundary: load on the last busy cycle is rejected
        do_reset();
        load(2'b01, 12'h000);
        e_ext = 1;
        repeat (TMRD - 1) @(negedge clk);
        check("R8 last busy cycle", busy, 1);
        load(2'b00, 12'h226);
        e_err = 1;
        check_state("R8 load in window rejected");
        check("R7 no dll on reject", dll, 0);

        // R8 boundary: load on the first free cycle is accepted
        do_reset();
        load(2'b01, 12'h000);
        e_ext = 1;
        repeat (TMRD) @(negedge clk);
        check("R8 free cycle", busy, 0);
        load(2'b00, 12'h232);
        model_main(12'h232);
        check_state("R8 load after window accepted");
        repeat (TMRD) @(negedge clk);

        // R3 R4 R5 R6 R7 R11 exhaustive payload sweep
        for (int a = 0; a < 4096; a++) begin
            load(2'b00, a[11:0]);
            model_main(a[11:0]);
            check_state("R3 R4 R5 R6 R11 sweep");
            check("R7 dll strobe", dll, a[8]);
            check("R8 busy after main", busy, 1);
            @(negedge clk);
            check("R7 dll single cycle", dll, 0);
            repeat (TMRD - 1) @(negedge clk);
        end

        // R9 open bank rejects main load, fields held
        for (int b = 0; b < NB; b++) begin
            bact = '0;
            bact[b] = 1'b1;
            load(2'b00, 12'h532);
            bact = '0;
            e_err = 1;
            check_state("R9 main with open bank");
            check("R9 no busy", busy, 0);
            check("R7 no dll on open bank", dll, 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule